// File: doc/BRIEF.md
# Pipelined Peripheral Slave Bridge

This block sits on a system bus as an AHB-style slave and presents one user-built peripheral with a simpler interface. It is a single flattened data phase. The peripheral sees a select line and the registered address of the current beat. It gets its own write strobe and its own read strobe, the transfer size and the burst type. Two flags tell the first beat of a burst (bus NONSEQ) from the beats that follow it (bus SEQ). Write data passes from the bus to the peripheral without a register, and read data passes back the same way.

The peripheral can stretch a beat by raising its wait input. The bridge then holds the bus ready line low. A bounded timeout normally ends the stall after a fixed number of wait cycles, even if the peripheral is still asking to wait. The beat then completes with an OKAY response and whatever read data is on the peripheral's bus. A second input from the peripheral lifts that limit, so it can wait for as long as it needs. The bridge claims a transfer only when the address falls inside one configured inclusive range. Every transfer gets an OKAY response.

Top module: `ahb_user_bridge`

## Requirements
- R1: A beat is accepted when, at a rising edge, `hsel`, `hready_in` and `hready_out` are all high, `htrans[1]` is 1, and `haddr` lies within [`RANGE_LO`, `RANGE_HI`] inclusive. In the next cycle `usr_sel` is high, and `usr_addr`, `usr_size` and `usr_burst` equal the `haddr`, `hsize` and `hburst` sampled at that edge. Sizes 0, 1 and 2 mean 8, 16 and 32 bits, and all eight burst codes (0 to 7) pass through unchanged.
- R2: During an accepted data phase, `usr_wr` equals the sampled `hwrite` and `usr_rd` is its inverse. Outside a data phase both are low, and they are never high together.
- R3: If `htrans` is IDLE (2'b00) or BUSY (2'b01), if `hsel` is low, or if the address is outside the range, no data phase follows. In the next cycle `usr_sel`, `usr_wr` and `usr_rd` are low and `hready_out` stays high, whatever `usr_wait` does.
- R4: `usr_bstart` is high in the data phase of a NONSEQ (2'b10) beat, and `usr_bcont` is high in the data phase of a SEQ (2'b11) beat. They are never high together, and both are low outside a data phase.
- R5: During a data phase, `usr_wdata` equals `hwdata` and `hrdata` equals `usr_rdata` in the same cycle.
- R6: With `usr_nolimit` high, `hready_out` stays low in every data-phase cycle in which `usr_wait` is high, with no upper bound.
- R7: With `usr_nolimit` low, a data phase has at most `MAX_WAIT` (16 by default) stall cycles. After that many, `hready_out` rises even if `usr_wait` is still high. `hresp` is always OKAY (2'b00).
- R8: The stall count starts again from zero in each new data phase, so each beat of a pipelined burst may use the full limit.
- R9: While `hready_out` is low, `usr_sel`, `usr_addr`, the strobes, `usr_size`, `usr_burst` and both burst flags hold their values.
- R10: During and right after synchronous reset, `usr_sel`, the strobes and both burst flags are low and `hready_out` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| hsel | input | 1 | Slave select from the bus decoder |
| haddr | input | 32 | Address-phase address |
| htrans | input | 2 | Transfer type: IDLE, BUSY, NONSEQ, SEQ |
| hwrite | input | 1 | Address-phase direction, 1 for write |
| hsize | input | 3 | Address-phase transfer size |
| hburst | input | 3 | Address-phase burst type |
| hwdata | input | 32 | Data-phase write data |
| hready_in | input | 1 | Bus-wide ready |
| hrdata | output | 32 | Read data to the bus |
| hready_out | output | 1 | Ready from this slave; low inserts a wait state |
| hresp | output | 2 | Transfer response, always OKAY |
| usr_sel | output | 1 | Peripheral selected for the current data phase |
| usr_addr | output | 32 | Address of the current beat |
| usr_wdata | output | 32 | Write data to the peripheral |
| usr_rdata | input | 32 | Read data from the peripheral |
| usr_wr | output | 1 | Current beat is a write |
| usr_rd | output | 1 | Current beat is a read |
| usr_size | output | 3 | Size of the current beat |
| usr_burst | output | 3 | Burst type of the current beat |
| usr_bstart | output | 1 | Current beat starts a burst |
| usr_bcont | output | 1 | Current beat continues a burst |
| usr_wait | input | 1 | Peripheral requests a wait state |
| usr_nolimit | input | 1 | Peripheral lifts the wait-state cap |

## Verification
Some properties are checked on every cycle. The strobes are never both high, and neither are the burst flags. A qualified beat is captured along with its address. An unqualified cycle leaves the select low. The address-phase values hold during a stall. Ready stays low during an unlimited wait. A run of low ready under the cap never exceeds the limit. Other behaviour only the bench scenarios can show: the exact stall count for each wait length on each side of the limit, the full restart of the count on every beat of a pipelined burst, the sweep of size, burst and direction codes, the range edges, and the data pass-through on both paths.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_BUSY   = 2'b01;
    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ    = 2'b11;

    localparam logic [1:0] RESP_OKAY = 2'b00;

    // One captured beat, carried from address phase into data phase.
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic [2:0]        size;
        logic [2:0]        burst;
        logic              first;
    } beat_t;

    function automatic logic trans_active(input logic [1:0] t);
        return t[1];
    endfunction

    function automatic logic addr_in_window(input logic [ADDR_W-1:0] a,
                                            input logic [ADDR_W-1:0] lo,
                                            input logic [ADDR_W-1:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/bridge_decode.sv
module bridge_decode
    import bridge_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RANGE_LO = 32'h4000_0000,
    parameter logic [ADDR_W-1:0] RANGE_HI = 32'h4000_0FFF
) (
    input  logic              hsel,
    input  logic              hready_in,
    input  logic [1:0]        htrans,
    input  logic [ADDR_W-1:0] haddr,
    input  logic              hwrite,
    input  logic [2:0]        hsize,
    input  logic [2:0]        hburst,
    output logic              hit,
    output beat_t             beat
);

    always_comb begin
        hit        = hsel && hready_in && trans_active(htrans)
                     && addr_in_window(haddr, RANGE_LO, RANGE_HI);
        beat.addr  = haddr;
        beat.write = hwrite;
        beat.size  = hsize;
        beat.burst = hburst;
        beat.first = (htrans == TR_NONSEQ);
    end

endmodule

// File: rtl/bridge_phase_reg.sv
module bridge_phase_reg
    import bridge_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  advance,
    input  logic  hit,
    input  beat_t next_beat,
    output logic  active,
    output beat_t cur
);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cur    <= '0;
        end else if (advance) begin
            active <= hit;
            if (hit) begin
                cur <= next_beat;
            end
        end
    end

endmodule

// File: rtl/bridge_wait_timer.sv
module bridge_wait_timer #(
    parameter int MAX_WAIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic usr_wait,
    input  logic usr_nolimit,
    output logic ready
);

    localparam int CNT_W = $clog2(MAX_WAIT + 1);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_WAIT);

    logic [CNT_W-1:0] cnt;
    logic             capped;

    always_comb begin
        capped = (cnt == CAP);
        ready  = !active || !usr_wait || (!usr_nolimit && capped);
    end

    always_ff @(posedge clk) begin
        if (rst || !active || ready) begin
            cnt <= '0;
        end else if (!capped) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ahb_user_bridge.sv
module ahb_user_bridge
    import bridge_pkg::*;
#(
    parameter logic [31:0] RANGE_LO = 32'h4000_0000,
    parameter logic [31:0] RANGE_HI = 32'h4000_0FFF,
    parameter int          MAX_WAIT = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        hsel,
    input  logic [31:0] haddr,
    input  logic [1:0]  htrans,
    input  logic        hwrite,
    input  logic [2:0]  hsize,
    input  logic [2:0]  hburst,
    input  logic [31:0] hwdata,
    input  logic        hready_in,
    output logic [31:0] hrdata,
    output logic        hready_out,
    output logic [1:0]  hresp,
    output logic        usr_sel,
    output logic [31:0] usr_addr,
    output logic [31:0] usr_wdata,
    input  logic [31:0] usr_rdata,
    output logic        usr_wr,
    output logic        usr_rd,
    output logic [2:0]  usr_size,
    output logic [2:0]  usr_burst,
    output logic        usr_bstart,
    output logic        usr_bcont,
    input  logic        usr_wait,
    input  logic        usr_nolimit
);

    logic  hit;
    logic  active;
    logic  ready;
    beat_t next_beat;
    beat_t cur;

    bridge_decode #(
        .RANGE_LO (RANGE_LO),
        .RANGE_HI (RANGE_HI)
    ) u_decode (
        .hsel      (hsel),
        .hready_in (hready_in),
        .htrans    (htrans),
        .haddr     (haddr),
        .hwrite    (hwrite),
        .hsize     (hsize),
        .hburst    (hburst),
        .hit       (hit),
        .beat      (next_beat)
    );

    bridge_phase_reg u_phase (
        .clk       (clk),
        .rst       (rst),
        .advance   (ready),
        .hit       (hit),
        .next_beat (next_beat),
        .active    (active),
        .cur       (cur)
    );

    bridge_wait_timer #(
        .MAX_WAIT (MAX_WAIT)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .active      (active),
        .usr_wait    (usr_wait),
        .usr_nolimit (usr_nolimit),
        .ready       (ready)
    );

    always_comb begin
        hready_out = ready;
        hresp      = RESP_OKAY;
        hrdata     = usr_rdata;
        usr_wdata  = hwdata;
        usr_sel    = active;
        usr_addr   = cur.addr;
        usr_size   = cur.size;
        usr_burst  = cur.burst;
        usr_wr     = active && cur.write;
        usr_rd     = active && !cur.write;
        usr_bstart = active && cur.first;
        usr_bcont  = active && !cur.first;
    end

endmodule

// File: rtl/bridge_chk.sv
module bridge_chk #(
    parameter logic [31:0] RANGE_LO = 32'h4000_0000,
    parameter logic [31:0] RANGE_HI = 32'h4000_0FFF,
    parameter int          MAX_WAIT = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        hsel,
    input logic [31:0] haddr,
    input logic [1:0]  htrans,
    input logic        hready_in,
    input logic        hready_out,
    input logic        usr_sel,
    input logic [31:0] usr_addr,
    input logic        usr_wr,
    input logic        usr_rd,
    input logic [2:0]  usr_size,
    input logic [2:0]  usr_burst,
    input logic        usr_bstart,
    input logic        usr_bcont,
    input logic        usr_wait,
    input logic        usr_nolimit
);

    localparam int RUN_W = $clog2(MAX_WAIT + 2) + 1;
    localparam logic [RUN_W-1:0] RUN_TOP = {RUN_W{1'b1}};

    logic [RUN_W-1:0] low_run;
    logic             qualified;

    assign qualified = hsel && hready_in && htrans[1]
                       && (haddr >= RANGE_LO) && (haddr <= RANGE_HI);

    always_ff @(posedge clk) begin
        if (rst || hready_out || usr_nolimit) begin
            low_run <= '0;
        end else if (low_run != RUN_TOP) begin
            low_run <= low_run + 1'b1;
        end
    end

    a_r1_capture: assert property (@(posedge clk) disable iff (rst)
        (qualified && hready_out) |=> (usr_sel && usr_addr == $past(haddr)));

    a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(usr_wr && usr_rd));

    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!qualified && hready_out) |=> (!usr_sel && !usr_wr && !usr_rd));

    a_r4_flags_excl: assert property (@(posedge clk) disable iff (rst)
        !(usr_bstart && usr_bcont));

    a_r6_unlimited_hold: assert property (@(posedge clk) disable iff (rst)
        (usr_sel && usr_wait && usr_nolimit) |-> !hready_out);

    a_r7_wait_cap: assert property (@(posedge clk) disable iff (rst)
        low_run <= RUN_W'(MAX_WAIT));

    a_r9_stall_stable: assert property (@(posedge clk) disable iff (rst)
        (usr_sel && !hready_out) |=> (usr_sel && $stable(usr_addr)
            && $stable(usr_wr) && $stable(usr_size) && $stable(usr_burst)
            && $stable(usr_bstart)));

endmodule

bind ahb_user_bridge bridge_chk #(
    .RANGE_LO (RANGE_LO),
    .RANGE_HI (RANGE_HI),
    .MAX_WAIT (MAX_WAIT)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .hsel        (hsel),
    .haddr       (haddr),
    .htrans      (htrans),
    .hready_in   (hready_in),
    .hready_out  (hready_out),
    .usr_sel     (usr_sel),
    .usr_addr    (usr_addr),
    .usr_wr      (usr_wr),
    .usr_rd      (usr_rd),
    .usr_size    (usr_size),
    .usr_burst   (usr_burst),
    .usr_bstart  (usr_bstart),
    .usr_bcont   (usr_bcont),
    .usr_wait    (usr_wait),
    .usr_nolimit (usr_nolimit)
);

// File: tb/ahb_user_bridge_bench.sv
`timescale 1ns/1ps
module ahb_user_bridge_bench;

    localparam logic [31:0] LO  = 32'h4000_0000;
    localparam logic [31:0] HI  = 32'h4000_0FFF;
    localparam int          CAP = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hsel = 1'b0;
    logic [31:0] haddr = '0;
    logic [1:0]  htrans = 2'b00;
    logic        hwrite = 1'b0;
    logic [2:0]  hsize = '0;
    logic [2:0]  hburst = '0;
    logic [31:0] hwdata = '0;
    logic        hready_in;
    logic [31:0] hrdata;
    logic        hready_out;
    logic [1:0]  hresp;
    logic        usr_sel;
    logic [31:0] usr_addr;
    logic [31:0] usr_wdata;
    logic [31:0] usr_rdata = '0;
    logic        usr_wr;
    logic        usr_rd;
    logic [2:0]  usr_size;
    logic [2:0]  usr_burst;
    logic        usr_bstart;
    logic        usr_bcont;
    logic        usr_wait = 1'b0;
    logic        usr_nolimit = 1'b0;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;
    assign hready_in = hready_out;

    ahb_user_bridge #(.RANGE_LO(LO), .RANGE_HI(HI), .MAX_WAIT(CAP)) u_ahb_user_bridge (
        .clk(clk), .rst(rst), .hsel(hsel), .haddr(haddr), .htrans(htrans),
        .hwrite(hwrite), .hsize(hsize), .hburst(hburst), .hwdata(hwdata),
        .hready_in(hready_in), .hrdata(hrdata), .hready_out(hready_out),
        .hresp(hresp), .usr_sel(usr_sel), .usr_addr(usr_addr),
        .usr_wdata(usr_wdata), .usr_rdata(usr_rdata), .usr_wr(usr_wr),
        .usr_rd(usr_rd), .usr_size(usr_size), .usr_burst(usr_burst),
        .usr_bstart(usr_bstart), .usr_bcont(usr_bcont), .usr_wait(usr_wait),
        .usr_nolimit(usr_nolimit)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One burst of n beats; wl = stall cycles the peripheral asks for per beat.
    task automatic run_burst(input logic [31:0] a0, input int n, input bit wr,
                             input logic [2:0] sz, input logic [2:0] bt,
                             input int wl, input bit nl);
        int exp_st;
        exp_st = nl ? wl : ((wl > CAP) ? CAP : wl);
        @(negedge clk);
        usr_wait = 1'b0;
        usr_nolimit = nl;
        hsel = 1'b1; haddr = a0; htrans = 2'b10; hwrite = wr;
        hsize = sz; hburst = bt;
        @(posedge clk);
        for (int i = 0; i < n; i++) begin
            int stalls;
            logic [31:0] wd, rd;
            wd = 32'h5A00_0000 ^ (a0 + 32'(i * 4));
            rd = 32'hC300_0000 ^ (a0 + 32'(i * 7));
            @(negedge clk);
            if (i + 1 < n) begin
                haddr = a0 + 32'((i + 1) * 4); htrans = 2'b11;
            end else begin
                hsel = 1'b0; htrans = 2'b00;
            end
            hwdata = wd; usr_rdata = rd;
            stalls = 0;
            usr_wait = (wl > 0);
            #0.5;
            check("R1 usr_sel", {31'd0, usr_sel}, 32'd1);
            check("R1 usr_addr", usr_addr, a0 + 32'(i * 4));
            check("R1 usr_size", {29'd0, usr_size}, {29'd0, sz});
            check("R1 usr_burst", {29'd0, usr_burst}, {29'd0, bt});
            check("R2 strobes", {30'd0, usr_wr, usr_rd}, {30'd0, wr, !wr});
            check("R4 flags", {30'd0, usr_bstart, usr_bcont},
                  (i == 0) ? 32'd2 : 32'd1);
            check("R5 wdata", usr_wdata, wd);
            check("R5 rdata", hrdata, rd);
            while (!hready_out && stalls < 200) begin
                stalls++;
                @(posedge clk);
                @(negedge clk);
                usr_wait = (stalls < wl);
                #0.5;
                check("R9 addr held", usr_addr, a0 + 32'(i * 4));
                check("R9 sel held", {31'd0, usr_sel}, 32'd1);
            end
            check(nl ? "R6 stall count" : (n > 1 ? "R8 stall count" : "R7 stall count"),
                  32'(stalls), 32'(exp_st));
            check("R7 hresp", {30'd0, hresp}, 32'd0);
            @(posedge clk);
        end
        @(negedge clk);
        usr_wait = 1'b0; usr_nolimit = 1'b0;
    endtask

    // Address phase that must not be claimed.
    task automatic no_claim(input string req, input bit sel, input logic [31:0] a,
                            input logic [1:0] tr);
        @(negedge clk);
        hsel = sel; haddr = a; htrans = tr; hwrite = 1'b1;
        @(posedge clk);
        @(negedge clk);
        hsel = 1'b0; htrans = 2'b00;
        usr_wait = 1'b1;
        #0.5;
        check(req, {29'd0, usr_sel, usr_wr, usr_rd}, 32'd0);
        check(req, {31'd0, hready_out}, 32'd1);
        @(negedge clk);
        usr_wait = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 reset sel", {27'd0, usr_sel, usr_wr, usr_rd, usr_bstart, usr_bcont}, 32'd0);
        check("R10 reset ready", {31'd0, hready_out}, 32'd1);
        rst = 1'b0;
        @(negedge clk);
        check("R10 after reset", {28'd0, usr_sel, usr_wr, usr_rd, !hready_out}, 32'd0);

        // R1 R2 R4 R5: sweep direction, size and burst codes
        for (int w = 0; w < 2; w++)
            for (int s = 0; s < 3; s++)
                for (int b = 0; b < 8; b++)
                    run_burst(LO + 32'(b * 64 + s * 8), 1, w[0], 3'(s), 3'(b), 0, 1'b0);

        // R1 range edges
        run_burst(LO, 1, 1'b1, 3'd2, 3'd0, 0, 1'b0);
        run_burst(HI, 1, 1'b0, 3'd0, 3'd0, 0, 1'b0);

        // R3 unclaimed cycles
        no_claim("R3 idle", 1'b1, LO + 32'h10, 2'b00);
        no_claim("R3 busy", 1'b1, LO + 32'h10, 2'b01);
        no_claim("R3 hsel low", 1'b0, LO + 32'h10, 2'b10);
        no_claim("R3 below range", 1'b1, LO - 32'd1, 2'b10);
        no_claim("R3 above range", 1'b1, HI + 32'd1, 2'b10);

        // R7 capped wait sweep across the limit
        for (int wl = 0; wl <= CAP + 4; wl++)
            run_burst(LO + 32'h100, 1, wl[0], 3'd2, 3'd0, wl, 1'b0);
        run_burst(LO + 32'h104, 1, 1'b0, 3'd2, 3'd0, 1000, 1'b0);

        // R6 unlimited wait beyond the cap
        for (int wl = CAP - 1; wl <= CAP + 25; wl += 13)
            run_burst(LO + 32'h200, 1, 1'b1, 3'd2, 3'd0, wl, 1'b1);

        // R8 pipelined bursts, each beat stalled to the limit
        run_burst(LO + 32'h300, 4, 1'b1, 3'd2, 3'd3, 1000, 1'b0);
        run_burst(LO + 32'h400, 3, 1'b0, 3'd1, 3'd1, 5, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule